// File: doc/BRIEF.md
# Switching-Period Sigma-Delta Bitstream Decimator

This block turns the 1-bit stream of a fast sigma-delta modulator into one multi-bit sample per power-converter switching period. The modulator clock drives the block. A period-start strobe from the PWM timing marks each frame boundary. Between two strobes the block counts the modulator clocks and the ones in the stream. This integrate-and-dump count works as a comb decimator, so the output rate follows the PWM frequency.

On each strobe the closed window is decoded. The window length fixes the effective resolution: 512 clocks give 9 bits and 64 clocks give 6 bits. The ones count becomes a signed value around the window midpoint. That value is clamped to the effective resolution and left-justified into a fixed 10-bit word, so the ±30 mV input span always maps to the same output scale. A one-cycle valid pulse marks each new result. Downstream compensation logic consumes the word and needs no knowledge of the switching frequency.

Top module: `sd_period_decim`

## Requirements
- R1: The ones count of a window covers every modulator clock from a strobe cycle (inclusive) up to the next strobe cycle (exclusive).
- R2: `valid_o` is high for exactly the one cycle after each clock edge at which `frame_i` was high, and low otherwise.
- R3: The ones counter and the length counter saturate at 2^CNT_W-1 (2047) instead of wrapping. A window of 3000 all-ones clocks yields resolution 10 and sample +511.
- R4: `res_o` equals floor(log2(N)) for a window of N clocks, limited to the range 1..OUT_W. N=64 gives 6, N=128 gives 7, N=256 gives 8 and N=512 gives 9.
- R5: The decoded value is K - floor(N/2) in two's complement, where K is the ones count. A half-density stream decodes to 0.
- R6: The decoded value is clamped to the signed range of `res_o` bits, from -2^(r-1) to 2^(r-1)-1.
- R7: `sample_o` is the clamped value shifted left by OUT_W - r. Its low OUT_W - r bits are zero, so halving N doubles the output weight of one count.
- R8: The midpoint comes from the measured window length. A window of 100 clocks with 60 ones therefore gives resolution 6 and sample 160.
- R9: After reset `sample_o` is 0, `res_o` is 0 and `valid_o` is 0.
- R10: `sample_o` and `res_o` hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Modulator clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bit_i | input | 1 | Modulator bitstream |
| frame_i | input | 1 | Switching-period start strobe |
| sample_o | output | 10 | Signed left-justified result |
| res_o | output | 4 | Effective resolution of the current result, in bits |
| valid_o | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench drives windows of 512, 256, 128 and 64 clocks, plus a 100-clock window, at chosen densities. An off-by-one in the window edges would move every result by one step. A fixed midpoint would misdecode the 100-clock window.

Full-density and zero-density windows exercise the clamp. Without the clamp, the +N/2 result wraps to a negative value.

Single-count steps at each frequency show whether the left shift tracks resolution. A missed shift gives the same output weight at every frequency.

A 3000-clock window with no strobe tests saturation. Counters that wrap would report a small or negative value instead of full scale.

// File: rtl/sd_decim_pkg.sv
package sd_decim_pkg;
    parameter int CNT_W = 11;
    parameter int OUT_W = 10;
    parameter int RES_W = 4;
endpackage

// File: rtl/sd_window_counter.sv
module sd_window_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bit_i,
    input  logic             frame_i,
    output logic [CNT_W-1:0] ones_o,
    output logic [CNT_W-1:0] len_o
);
    localparam logic [CNT_W-1:0] CntMax = '1;

    typedef struct packed {
        logic [CNT_W-1:0] ones;
        logic [CNT_W-1:0] len;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (frame_i) begin
            cnt_d.ones = CNT_W'(bit_i);
            cnt_d.len  = CNT_W'(1);
        end else begin
            if (cnt_q.len != CntMax) cnt_d.len = cnt_q.len + CNT_W'(1);
            if (bit_i && cnt_q.ones != CntMax) cnt_d.ones = cnt_q.ones + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign ones_o = cnt_q.ones;
    assign len_o  = cnt_q.len;
endmodule

// File: rtl/sd_res_calc.sv
module sd_res_calc #(
    parameter int CNT_W = 11,
    parameter int OUT_W = 10,
    parameter int RES_W = 4
) (
    input  logic [CNT_W-1:0] len_i,
    output logic [RES_W-1:0] res_o
);
    // floor(log2(len)) limited to 1..OUT_W
    always_comb begin
        res_o = RES_W'(1);
        for (int i = 1; i <= OUT_W; i++) begin
            if (32'(len_i) >= (32'd1 << i)) res_o = RES_W'(i);
        end
    end
endmodule

// File: rtl/sd_scale.sv
module sd_scale #(
    parameter int CNT_W = 11,
    parameter int OUT_W = 10,
    parameter int RES_W = 4
) (
    input  logic [CNT_W-1:0]        ones_i,
    input  logic [CNT_W-1:0]        len_i,
    input  logic [RES_W-1:0]        res_i,
    output logic signed [OUT_W-1:0] value_o
);
    localparam int W = CNT_W + 2;

    logic signed [W-1:0] diff, half, hi, lo, clip, shf;

    always_comb begin
        diff = $signed({2'b00, ones_i}) - $signed({3'b000, len_i[CNT_W-1:1]});
        half = $signed(W'(1) << (res_i - RES_W'(1)));
        hi   = half - W'(1);
        lo   = -half;
        if (diff > hi)      clip = hi;
        else if (diff < lo) clip = lo;
        else                clip = diff;
        shf     = clip <<< (OUT_W - int'(res_i));
        value_o = shf[OUT_W-1:0];
    end
endmodule

// File: rtl/sd_period_decim.sv
module sd_period_decim
    import sd_decim_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int OW = OUT_W,
    parameter int RW = RES_W
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          bit_i,
    input  logic          frame_i,
    output logic [OW-1:0] sample_o,
    output logic [RW-1:0] res_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [OW-1:0] sample;
        logic [RW-1:0] res;
        logic          valid;
    } out_t;

    logic [CW-1:0] ones_w, len_w;
    logic [RW-1:0] res_w;
    logic signed [OW-1:0] value_w;
    out_t st_d, st_q;

    sd_window_counter #(.CNT_W(CW)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .bit_i  (bit_i),
        .frame_i(frame_i),
        .ones_o (ones_w),
        .len_o  (len_w)
    );

    sd_res_calc #(.CNT_W(CW), .OUT_W(OW), .RES_W(RW)) u_res (
        .len_i(len_w),
        .res_o(res_w)
    );

    sd_scale #(.CNT_W(CW), .OUT_W(OW), .RES_W(RW)) u_scale (
        .ones_i (ones_w),
        .len_i  (len_w),
        .res_i  (res_w),
        .value_o(value_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = frame_i;
        if (frame_i) begin
            st_d.sample = value_w;
            st_d.res    = res_w;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sample_o = st_q.sample;
    assign res_o    = st_q.res;
    assign valid_o  = st_q.valid;
endmodule

// File: rtl/sd_period_decim_chk.sv
module sd_period_decim_chk #(
    parameter int CW = 11,
    parameter int OW = 10,
    parameter int RW = 4
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          frame_i,
    input logic [OW-1:0] sample_o,
    input logic [RW-1:0] res_o,
    input logic          valid_o,
    input logic [CW-1:0] ones_q,
    input logic [CW-1:0] len_q
);
    logic [OW-1:0] low_mask;
    always_comb low_mask = OW'((32'd1 << (OW - int'(res_o))) - 32'd1);

    p_valid_after_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_i |=> valid_o);
    p_valid_only_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> !valid_o);
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> len_q >= $past(len_q));
    p_ones_within_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ones_q <= len_q);
    p_res_bounds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (res_o >= RW'(1) && res_o <= RW'(OW)));
    p_low_bits_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> (sample_o & low_mask) == '0);
    p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_i |=> $stable(sample_o) && $stable(res_o));
endmodule

bind sd_period_decim sd_period_decim_chk #(.CW(CW), .OW(OW), .RW(RW)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .sample_o(sample_o),
    .res_o   (res_o),
    .valid_o (valid_o),
    .ones_q  (ones_w),
    .len_q   (len_w)
);

// File: tb/sd_period_decim_tb.sv
module sd_period_decim_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_s = 1'b0;
    logic       frame_s = 1'b0;
    logic [9:0] sample;
    logic [3:0] res;
    logic       valid;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sd_period_decim dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .bit_i   (bit_s),
        .frame_i (frame_s),
        .sample_o(sample),
        .res_o   (res),
        .valid_o (valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int expect_res(input int n);
        int r = 1;
        for (int i = 1; i <= 10; i++) if (n >= (1 << i)) r = i;
        return r;
    endfunction

    function automatic int expect_val(input int n, input int k);
        int r = expect_res(n);
        int v = k - n / 2;
        int h = 1 << (r - 1);
        if (v > h - 1) v = h - 1;
        if (v < -h) v = -h;
        return v * (1 << (10 - r));
    endfunction

    // one window of n clocks with k leading ones, closed by a strobe
    task automatic run_window(input string tag, input int n, input int k);
        int ev = expect_val(n, k);
        int er = expect_res(n);
        int held;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_s = (i == 0);
            bit_s   = (i < k);
        end
        @(negedge clk);
        frame_s = 1'b1;
        bit_s   = 1'b0;
        @(negedge clk);
        frame_s = 1'b0;
        check({tag, " R2 valid"}, int'(valid), 1);
        check({tag, " R5/R6/R7 sample"}, int'($signed(sample)), ev);
        check({tag, " R4 res"}, int'(res), er);
        held = int'($signed(sample));
        @(negedge clk);
        check({tag, " R2 valid drop"}, int'(valid), 0);
        check({tag, " R10 hold"}, int'($signed(sample)), held);
    endtask

    task automatic test_reset();
        check("R9 sample", int'(sample), 0);
        check("R9 res", int'(res), 0);
        check("R9 valid", int'(valid), 0);
    endtask

    task automatic test_freqs();
        run_window("R1 512 mid", 512, 256);
        run_window("R1 512 k300", 512, 300);
        run_window("R6 512 zero", 512, 0);
        run_window("R6 512 full", 512, 512);
        run_window("R4 256", 256, 192);
        run_window("R4 128", 128, 32);
        run_window("R4 64", 64, 40);
    endtask

    task automatic test_step();
        run_window("R7 step 512", 512, 257);
        run_window("R7 step 256", 256, 129);
        run_window("R7 step 128", 128, 65);
        run_window("R7 step 64", 64, 33);
    endtask

    task automatic test_odd();
        run_window("R8 len 100", 100, 60);
    endtask

    task automatic test_sat();
        run_window("R3 saturate", 3000, 3000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_freqs();
        test_step();
        test_odd();
        test_sat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule